// File: doc/BRIEF.md
# Phase-Aware Host Byte FIFO with Handshake Status

This block sits between the processor bus and the core of a disk controller. It holds a byte queue and produces the two handshake status bits that host software polls: a request bit (`rqm_o`), which says the host may move a byte now, and a direction bit (`dio_o`), which says which way that byte flows. The core supplies the current transfer phase: command, execution or result. During execution it also supplies the direction of data flow.

Out of reset the queue behaves as a single byte register. The configure inputs, loaded by a strobe, can turn on the full queue and set a service threshold. Even with the queue on, its usable depth drops to one byte in the command and result phases. Software written for a one-byte register then still sees one handshake per byte. In the execution phase the whole depth is used, and a service request fires when enough data or enough free space has built up. Any change of phase discards whatever bytes are still queued.

The host side is a read/write byte port. The core side pushes bytes toward the host and pops bytes that came from the host. Its read data is shown ahead, so the head byte is visible before it is popped.

Top module: `phased_host_fifo`

## Requirements
- R1: After reset the phase is command, the queue is empty and in byte mode, `rqm_o`=1, `dio_o`=0, `svc_req_o`=0, both error flags are 0 and `host_rdata_o` is 0.
- R2: In the command phase (`phase_i`=0, the code 3 is treated as command) the usable depth is one byte, even with the queue enabled. After one accepted host write `rqm_o` is 0 until the core pops that byte, and a second host write is not stored.
- R3: In the result phase (`phase_i`=2) `dio_o`=1 and the usable depth is one byte. `core_space_o` is 1 only while the queue is empty, a second core push is dropped, and `rqm_o` is 1 exactly while a byte waits for the host.
- R4: `dio_o` is 0 in the command phase and in execution with `xfer_dir_i`=0 (host to disk). It is 1 in the result phase and in execution (`phase_i`=1) with `xfer_dir_i`=1. With `dio_o`=0, `rqm_o` means a byte can be accepted; with `dio_o`=1 it means a byte can be read.
- R5: In execution with the queue enabled, 16 bytes are held in arrival order. Toward the core, `rqm_o` stays 1 until the 16th write. Toward the host, `core_space_o` stays 1 until the 16th push.
- R6: In execution with the queue disabled, the depth is one byte.
- R7: `svc_req_o` is 0 outside execution. In execution with the queue enabled and threshold field T, it is 1 when at least T+1 bytes are stored (`dio_o`=1) or at least T+1 bytes are free (`dio_o`=0). With the queue disabled it equals `rqm_o`.
- R8: A host write while `rqm_o`=0 or `dio_o`=1 is not stored, and it sets `overrun_o`, which stays 1 until reset.
- R9: A host read while `rqm_o`=0 or `dio_o`=0 leaves `host_rdata_o` at its previous byte, and it sets `underrun_o`, which stays 1 until reset.
- R10: A change of `phase_i` empties the queue at the next clock edge.
- R11: The enable and threshold take effect only on a clock edge where `cfg_wr_i`=1. Changes on `cfg_fifo_en_i` or `cfg_thresh_i` without the strobe have no effect.
- R12: An accepted host read places the head byte on `host_rdata_o` one cycle later, and the byte holds there until the next accepted read. `core_rdata_o` shows the head byte before it is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_i | input | 2 | Transfer phase: 0 command, 1 execution, 2 result, 3 treated as command |
| xfer_dir_i | input | 1 | Execution direction: 1 toward host, 0 toward core |
| cfg_wr_i | input | 1 | Configure load strobe |
| cfg_fifo_en_i | input | 1 | Queue enable value to load |
| cfg_thresh_i | input | 4 | Threshold field T, request level T+1 |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 8 | Last byte read by the host |
| core_push_i | input | 1 | Core push strobe (toward host) |
| core_wdata_i | input | 8 | Core push byte |
| core_pop_i | input | 1 | Core pop strobe (host bytes) |
| core_rdata_o | output | 8 | Head byte, shown ahead |
| core_avail_o | output | 1 | A host byte is waiting for the core |
| core_space_o | output | 1 | The core may push a byte |
| rqm_o | output | 1 | Host may transfer a byte now |
| dio_o | output | 1 | Transfer direction, 1 toward host |
| svc_req_o | output | 1 | Execution-phase service request |
| overrun_o | output | 1 | Sticky: rejected host write |
| underrun_o | output | 1 | Sticky: rejected host read |

## Verification
A wrong fill count or pointer shows at the ports on the next cycle. `rqm_o` or `core_space_o` then flips one byte early or late, and the bytes seen on `core_rdata_o` or `host_rdata_o` arrive out of order. A missed flush leaves stale bytes that appear as `core_avail_o` or `rqm_o` right after a phase change. A wrong effective depth shows up in the command or result phase as a second byte being accepted. A stale configure register shows as a service request at the wrong fill level.

// File: rtl/hfifo_pkg.sv
// Shared types for the phase-aware host FIFO.
package hfifo_pkg;
    // Transfer phase as driven by the controller core.
    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_EXEC  = 2'd1,
        PH_RES   = 2'd2,
        PH_SPARE = 2'd3
    } phase_e;
endpackage

// File: rtl/hf_store.sv
// Byte storage ring with fill counter.
// Assumes the caller never pushes when full or pops when empty.
// A flush takes priority over push and pop.
module hf_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] fill
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Write the incoming byte into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= wdata;
    end

    // Advance the pointers and the fill count, or clear them on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      fill <= fill + CW'(1);
            else if (pop && !push) fill <= fill - CW'(1);
        end
    end

    assign rdata = mem[rd_ptr];
endmodule

// File: rtl/hf_status.sv
// Combinational handshake logic: effective depth, direction and request bits,
// acceptance of host and core strokes, and the service request.
// Assumes phase is already registered and that the spare code maps to command.
module hf_status
    import hfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  phase_e        phase,
    input  logic          dir_out,
    input  logic          en,
    input  logic [TW-1:0] thr,
    input  logic [CW-1:0] fill,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          core_push,
    input  logic          core_pop,
    output logic          rqm,
    output logic          dio,
    output logic          push,
    output logic          pop,
    output logic          sel_host,
    output logic          rd_take,
    output logic          wr_reject,
    output logic          rd_reject,
    output logic          svc,
    output logic          core_avail,
    output logic          core_space
);
    logic [CW-1:0] cap, level, room;
    logic          has_room, has_data, wr_take, cpush_take, cpop_take, in_exec;

    // Work out the usable depth, direction and raw fill conditions.
    always_comb begin
        in_exec  = (phase == PH_EXEC);
        cap      = (en && in_exec) ? CW'(DEPTH) : CW'(1);
        dio      = (phase == PH_RES) || (in_exec && dir_out);
        has_room = (fill < cap);
        has_data = (fill != '0);
        rqm      = dio ? has_data : has_room;
    end

    // Decide which strokes are accepted and which are rejected.
    always_comb begin
        wr_take    = host_wr && rqm && !dio;
        rd_take    = host_rd && rqm && dio;
        wr_reject  = host_wr && !wr_take;
        rd_reject  = host_rd && !rd_take;
        cpush_take = core_push && dio && has_room;
        cpop_take  = core_pop && !dio && has_data;
        push       = wr_take || cpush_take;
        pop        = rd_take || cpop_take;
        sel_host   = !dio;
        core_avail = !dio && has_data;
        core_space = dio && has_room;
    end

    // Raise the execution-phase service request at the threshold.
    always_comb begin
        level = CW'(thr) + CW'(1);
        room  = CW'(DEPTH) - fill;
        if (!in_exec)  svc = 1'b0;
        else if (!en)  svc = rqm;
        else if (dio)  svc = (fill >= level);
        else           svc = (room >= level);
    end
endmodule

// File: rtl/phased_host_fifo.sv
// Top level of the phase-aware host FIFO. Registers the phase and the
// configuration, flushes on a phase change, keeps the host read byte and
// the sticky error flags. Assumes a synchronous active-low reset.
module phased_host_fifo
    import hfifo_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    phase_i,
    input  logic          xfer_dir_i,
    input  logic          cfg_wr_i,
    input  logic          cfg_fifo_en_i,
    input  logic [TW-1:0] cfg_thresh_i,
    input  logic          host_wr_i,
    input  logic [DW-1:0] host_wdata_i,
    input  logic          host_rd_i,
    output logic [DW-1:0] host_rdata_o,
    input  logic          core_push_i,
    input  logic [DW-1:0] core_wdata_i,
    input  logic          core_pop_i,
    output logic [DW-1:0] core_rdata_o,
    output logic          core_avail_o,
    output logic          core_space_o,
    output logic          rqm_o,
    output logic          dio_o,
    output logic          svc_req_o,
    output logic          overrun_o,
    output logic          underrun_o
);
    phase_e        phase_q, phase_n;
    logic          en_q;
    logic [TW-1:0] thr_q;
    logic [CW-1:0] fill;
    logic          flush, push, pop, sel_host, rd_take, wr_reject, rd_reject;
    logic [DW-1:0] head;

    // Map the spare phase code onto command and detect a phase change.
    always_comb begin
        phase_n = (phase_i == 2'd3) ? PH_CMD : phase_e'(phase_i);
        flush   = (phase_n != phase_q);
    end

    // Track the phase one cycle behind the input.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_CMD;
        else        phase_q <= phase_n;
    end

    // Load enable and threshold only on the configure strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            thr_q <= '0;
        end else if (cfg_wr_i) begin
            en_q  <= cfg_fifo_en_i;
            thr_q <= cfg_thresh_i;
        end
    end

    // Capture the head byte on an accepted host read.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata_o <= '0;
        else if (rd_take) host_rdata_o <= head;
    end

    // Keep the sticky overrun and underrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_o  <= 1'b0;
            underrun_o <= 1'b0;
        end else begin
            if (wr_reject) overrun_o  <= 1'b1;
            if (rd_reject) underrun_o <= 1'b1;
        end
    end

    hf_status #(.DEPTH(DEPTH)) u_status (
        .phase      (phase_q),
        .dir_out    (xfer_dir_i),
        .en         (en_q),
        .thr        (thr_q),
        .fill       (fill),
        .host_wr    (host_wr_i),
        .host_rd    (host_rd_i),
        .core_push  (core_push_i),
        .core_pop   (core_pop_i),
        .rqm        (rqm_o),
        .dio        (dio_o),
        .push       (push),
        .pop        (pop),
        .sel_host   (sel_host),
        .rd_take    (rd_take),
        .wr_reject  (wr_reject),
        .rd_reject  (rd_reject),
        .svc        (svc_req_o),
        .core_avail (core_avail_o),
        .core_space (core_space_o)
    );

    hf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .pop   (pop),
        .wdata (sel_host ? host_wdata_i : core_wdata_i),
        .rdata (head),
        .fill  (fill)
    );

    assign core_rdata_o = head;
endmodule

// File: rtl/phf_checker.sv
// Property checker for phased_host_fifo, attached by bind.
// Observes ports plus the registered phase and the fill count.
module phf_checker #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    phase_i,
    input logic [1:0]    phase_q,
    input logic [CW-1:0] fill,
    input logic          host_wr_i,
    input logic          host_rd_i,
    input logic [DW-1:0] host_rdata_o,
    input logic          rqm_o,
    input logic          dio_o,
    input logic          svc_req_o,
    input logic          overrun_o,
    input logic          underrun_o
);
    logic [1:0] ph_in;
    assign ph_in = (phase_i == 2'd3) ? 2'd0 : phase_i;

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o); // R8
    AST_BAD_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && !(rqm_o && !dio_o)) |=> overrun_o); // R8
    AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> underrun_o); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd_i && rqm_o && dio_o) |=> $stable(host_rdata_o)); // R12
    AST_BYTE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != 2'd1) |-> (fill <= CW'(1))); // R2
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH)); // R5
    AST_PHASE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_in != phase_q) |=> (fill == '0)); // R10
    AST_SVC_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req_o |-> (phase_q == 2'd1)); // R7
endmodule

bind phased_host_fifo phf_checker #(.DW(DW), .DEPTH(DEPTH)) u_phf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_i      (phase_i),
    .phase_q      (phase_q),
    .fill         (fill),
    .host_wr_i    (host_wr_i),
    .host_rd_i    (host_rd_i),
    .host_rdata_o (host_rdata_o),
    .rqm_o        (rqm_o),
    .dio_o        (dio_o),
    .svc_req_o    (svc_req_o),
    .overrun_o    (overrun_o),
    .underrun_o   (underrun_o)
);

// File: tb/tb_phased_host_fifo.sv
`timescale 1ns/1ps
module tb_phased_host_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] phase_i = 2'd0;
    logic       xfer_dir_i = 1'b0;
    logic       cfg_wr_i = 1'b0, cfg_fifo_en_i = 1'b0;
    logic [3:0] cfg_thresh_i = 4'd0;
    logic       host_wr_i = 1'b0, host_rd_i = 1'b0;
    logic [7:0] host_wdata_i = 8'h00, host_rdata_o;
    logic       core_push_i = 1'b0, core_pop_i = 1'b0;
    logic [7:0] core_wdata_i = 8'h00, core_rdata_o;
    logic       core_avail_o, core_space_o, rqm_o, dio_o, svc_req_o;
    logic       overrun_o, underrun_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    phased_host_fifo dut (
        .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .xfer_dir_i(xfer_dir_i),
        .cfg_wr_i(cfg_wr_i), .cfg_fifo_en_i(cfg_fifo_en_i), .cfg_thresh_i(cfg_thresh_i),
        .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i), .host_rd_i(host_rd_i),
        .host_rdata_o(host_rdata_o), .core_push_i(core_push_i), .core_wdata_i(core_wdata_i),
        .core_pop_i(core_pop_i), .core_rdata_o(core_rdata_o), .core_avail_o(core_avail_o),
        .core_space_o(core_space_o), .rqm_o(rqm_o), .dio_o(dio_o), .svc_req_o(svc_req_o),
        .overrun_o(overrun_o), .underrun_o(underrun_o)
    );

    typedef struct packed {
        logic [1:0] ph;
        logic       dir, hwr, hrd, cpush, cpop;
        logic [7:0] din;
        logic       e_rqm, e_dio, e_svc, e_avail;
        logic [7:0] e_rd;
    } vec_t;

    localparam int NV = 11;
    // Byte-mode handshake walk: queue disabled, one stroke per row.
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hB2, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
        '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC3},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC3},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hD4, 1'b1, 1'b1, 1'b1, 1'b0, 8'hC3},
        '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hD4},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'hD4}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // One clock edge, then return at the falling edge with strobes cleared.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        host_wr_i = 1'b0; host_rd_i = 1'b0;
        core_push_i = 1'b0; core_pop_i = 1'b0; cfg_wr_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        chk_eq("R1 rqm", rqm_o, 1);
        chk_eq("R1 dio", dio_o, 0);
        chk_eq("R1 svc", svc_req_o, 0);
        chk_eq("R1 avail", core_avail_o, 0);
        chk_eq("R1 flags", {overrun_o, underrun_o}, 0);
        chk_eq("R1 rdata", host_rdata_o, 0);

        // R2 R3 R4 R6 R7 R10 R12: byte-mode table walk.
        for (int k = 0; k < NV; k++) begin
            phase_i = VEC[k].ph; xfer_dir_i = VEC[k].dir;
            host_wr_i = VEC[k].hwr; host_rd_i = VEC[k].hrd;
            core_push_i = VEC[k].cpush; core_pop_i = VEC[k].cpop;
            host_wdata_i = VEC[k].din; core_wdata_i = VEC[k].din;
            cyc();
            chk_eq($sformatf("R2/R4 rqm row %0d", k), rqm_o, VEC[k].e_rqm);
            chk_eq($sformatf("R4 dio row %0d", k), dio_o, VEC[k].e_dio);
            chk_eq($sformatf("R6/R7 svc row %0d", k), svc_req_o, VEC[k].e_svc);
            chk_eq($sformatf("R3/R10 avail row %0d", k), core_avail_o, VEC[k].e_avail);
            chk_eq($sformatf("R12 rdata row %0d", k), host_rdata_o, VEC[k].e_rd);
        end
        chk_eq("R8 no spurious overrun", overrun_o, 0);
        chk_eq("R9 no spurious underrun", underrun_o, 0);

        // R11: configure values without the strobe leave byte mode in place.
        cfg_fifo_en_i = 1'b1; cfg_thresh_i = 4'd3;
        phase_i = 2'd1; xfer_dir_i = 1'b0; cyc();
        host_wr_i = 1'b1; host_wdata_i = 8'h55; cyc();
        chk_eq("R11 unstrobed enable ignored rqm", rqm_o, 0);
        core_pop_i = 1'b1; cyc();
        phase_i = 2'd0; cyc();
        cfg_wr_i = 1'b1; cyc();

        // R5 R7: execution toward core, 16 deep, threshold level 4 on free space.
        phase_i = 2'd1; xfer_dir_i = 1'b0; cyc();
        chk_eq("R7 svc empty inward", svc_req_o, 1);
        for (int i = 0; i < 16; i++) begin
            host_wr_i = 1'b1; host_wdata_i = 8'h10 + 8'(i); cyc();
            if (i == 11) chk_eq("R7 svc free=4", svc_req_o, 1);
            if (i == 12) chk_eq("R7 svc free=3", svc_req_o, 0);
            if (i == 14) chk_eq("R5 rqm at 15", rqm_o, 1);
            if (i == 15) chk_eq("R5 rqm at 16", rqm_o, 0);
        end
        // R8: write into a full queue is dropped and flagged.
        host_wr_i = 1'b1; host_wdata_i = 8'hEE; cyc();
        chk_eq("R8 overrun set", overrun_o, 1);
        for (int i = 0; i < 16; i++) begin
            chk_eq("R5 avail", core_avail_o, 1);
            chk_eq("R5/R12 order", core_rdata_o, 8'h10 + 8'(i));
            core_pop_i = 1'b1; cyc();
        end
        chk_eq("R8 dropped byte absent", core_avail_o, 0);

        // R5 R7: execution toward host, threshold level 4 on stored bytes.
        xfer_dir_i = 1'b1; cyc();
        chk_eq("R4 dio outward", dio_o, 1);
        chk_eq("R7 svc empty outward", svc_req_o, 0);
        for (int i = 0; i < 16; i++) begin
            core_push_i = 1'b1; core_wdata_i = 8'h30 + 8'(i); cyc();
            if (i == 2)  chk_eq("R7 svc at 3", svc_req_o, 0);
            if (i == 3)  chk_eq("R7 svc at 4", svc_req_o, 1);
            if (i == 14) chk_eq("R5 space at 15", core_space_o, 1);
            if (i == 15) chk_eq("R5 space at 16", core_space_o, 0);
        end
        for (int i = 0; i < 16; i++) begin
            host_rd_i = 1'b1; cyc();
            chk_eq("R12 host read order", host_rdata_o, 8'h30 + 8'(i));
        end
        // R9: read from an empty queue keeps the last byte.
        host_rd_i = 1'b1; cyc();
        chk_eq("R9 rdata held", host_rdata_o, 8'h3F);
        chk_eq("R9 underrun set", underrun_o, 1);

        // R2: enabled queue still holds one byte in the command phase.
        phase_i = 2'd0; xfer_dir_i = 1'b0; cyc();
        chk_eq("R7 svc off in command", svc_req_o, 0);
        host_wr_i = 1'b1; host_wdata_i = 8'h61; cyc();
        chk_eq("R2 rqm after one", rqm_o, 0);
        host_wr_i = 1'b1; host_wdata_i = 8'h62; cyc();
        chk_eq("R2 head byte", core_rdata_o, 8'h61);
        core_pop_i = 1'b1; cyc();
        chk_eq("R2 second byte dropped", core_avail_o, 0);

        // R10: a phase change discards queued bytes.
        phase_i = 2'd1; cyc();
        for (int i = 0; i < 5; i++) begin
            host_wr_i = 1'b1; host_wdata_i = 8'h70 + 8'(i); cyc();
        end
        chk_eq("R10 bytes queued", core_avail_o, 1);
        phase_i = 2'd0; cyc();
        chk_eq("R10 flushed avail", core_avail_o, 0);
        chk_eq("R10 flushed rqm", rqm_o, 1);

        // R3: result phase holds one byte.
        phase_i = 2'd2; cyc();
        chk_eq("R3 space empty", core_space_o, 1);
        chk_eq("R3 rqm empty", rqm_o, 0);
        core_push_i = 1'b1; core_wdata_i = 8'h81; cyc();
        chk_eq("R3 space full", core_space_o, 0);
        core_push_i = 1'b1; core_wdata_i = 8'h82; cyc();
        host_rd_i = 1'b1; cyc();
        chk_eq("R3 first byte read", host_rdata_o, 8'h81);
        chk_eq("R3 second push dropped", rqm_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule